// File: doc/BRIEF.md
# Rotating Shared-Bank Cluster Register File

This block is the register storage for a four-cluster wide-issue signal processor. Each cluster owns a private bank of eight registers, reached by specifiers 0 to 7. The two load/store clusters (0 and 1) hold 32-bit private registers. The two arithmetic clusters (2 and 3) hold 40-bit private registers so that they can keep accumulator guard bits. Specifiers 8 to 15 reach a second set of eight 32-bit registers. These live in one of four shared banks that are linked as a ring.

Each bundle carries a 2-bit rotation value. While that value is k, cluster c sees shared bank (c + k) mod 4. Because the rotation is a permutation, every shared bank serves exactly one cluster in any cycle. Each bank therefore needs only two read ports and two write ports, and no single sixteen-port array is needed. Data produced by one cluster reaches another cluster by changing the rotation, not by copying.

All data ports are 40 bits wide. Reads are combinational from the current state, and writes commit on the clock edge. Per-port narrow flags handle the 32-bit/40-bit boundary.

Top module: `ring_regfile`

## Requirements
- R1: After reset, every private and shared register reads as zero.
- R2: Specifier bit 3 low selects the issuing cluster's own private bank, addressed by bits 2:0. A write there is invisible to the same specifier in any other cluster.
- R3: Specifier bit 3 high selects shared bank (c + rot) mod 4 for cluster c, where rot is the rotation input, addressed by bits 2:0.
- R4: The rotation value applies to reads and writes in the same cycle that it is presented.
- R5: A read returns the state before the current clock edge. A register written in a cycle shows its old value during that cycle and its new value in the next cycle.
- R6: When both write ports of one cluster hit the same register in one cycle, the value from port 1 (the odd-numbered port of the pair) is stored.
- R7: Registers in clusters 0 and 1 and all shared registers are 32 bits. A write stores the low 32 bits, and a normal read returns them sign-extended to 40 bits. Registers in clusters 2 and 3 store and return all 40 bits.
- R8: A write with its narrow flag set sign-extends data bit 31 into bits 39:32 before storing.
- R9: A read with its narrow flag set returns the low 32 bits of the register, with bits 39:32 zero.
- R10: A write port whose enable is low changes no register, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_rot | input | 2 | Rotation value of the current bundle |
| rd_addr | input | 8x4 | Read specifiers; port p belongs to cluster p/2 |
| rd_narrow | input | 8 | Per read port: return low 32 bits, upper bits zero |
| rd_data | output | 8x40 | Read data, combinational |
| wr_en | input | 8 | Per write port enable; port p belongs to cluster p/2 |
| wr_narrow | input | 8 | Per write port: sign-extend data bit 31 |
| wr_addr | input | 8x4 | Write specifiers |
| wr_data | input | 8x40 | Write data |

## Verification
The bench targets the rotation arithmetic. A shared write at one rotation is read back from other clusters at other rotations, including the wrap-around case (1 + 3 mod 4). All four clusters also write the shared ring at once. A design that adds instead of subtracts when routing writes, or that latches the rotation one cycle late, would put data in the wrong bank and return zero or a neighbour's value.

Several other errors would return wrong values. A read taken in the same cycle as a write exposes write-through forwarding. A same-register double write exposes a reversed port priority. A 40-bit write into a 32-bit register, and narrow reads and writes, expose missing or misplaced sign extension. A write with data and address driven but enable low exposes a register that ignores its enable.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int CLUSTERS  = 4;
  localparam int PORTS_CL  = 2;
  localparam int BANK_REGS = 8;
  localparam int WIDE_W    = 40;
  localparam int SLIM_W    = 32;
  localparam logic [CLUSTERS-1:0] WIDE_SET = 4'b1100;
endpackage

// File: rtl/rrf_bank.sv
module rrf_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int BUS_W = 40,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NW-1:0]              we,
  input  logic [NW-1:0][IW-1:0]      waddr,
  input  logic [NW-1:0][BUS_W-1:0]   wdata,
  input  logic [NR-1:0][IW-1:0]      raddr,
  output logic [NR-1:0][W-1:0]       rdata
);
  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
  logic                    mem_en;

  always_comb begin
    mem_d  = mem_q;
    mem_en = |we;
    for (int w = 0; w < NW; w++) begin
      if (we[w]) mem_d[waddr[w]] = wdata[w][W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdata[r] = mem_q[raddr[r]];
  end
endmodule

// File: rtl/rrf_ring.sv
module rrf_ring #(
  parameter int NCL    = 4,
  parameter int NP     = 2,
  parameter int DEPTH  = 8,
  parameter int RING_W = 32,
  parameter int BUS_W  = 40,
  localparam int CW    = $clog2(NCL),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [CW-1:0]                        rot,
  input  logic [NCL-1:0][NP-1:0]               we,
  input  logic [NCL-1:0][NP-1:0][IW-1:0]       waddr,
  input  logic [NCL-1:0][NP-1:0][BUS_W-1:0]    wdata,
  input  logic [NCL-1:0][NP-1:0][IW-1:0]       raddr,
  output logic [NCL-1:0][NP-1:0][RING_W-1:0]   rdata
);
  logic [NCL-1:0][NP-1:0][RING_W-1:0] bank_q;

  for (genvar b = 0; b < NCL; b++) begin : g_bank
    logic [CW-1:0] owner;
    assign owner = CW'(b) - rot;
    rrf_bank #(.W(RING_W), .DEPTH(DEPTH), .NW(NP), .NR(NP), .BUS_W(BUS_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we[owner]),
      .waddr(waddr[owner]),
      .wdata(wdata[owner]),
      .raddr(raddr[owner]),
      .rdata(bank_q[b])
    );
  end

  for (genvar c = 0; c < NCL; c++) begin : g_view
    logic [CW-1:0] seen;
    assign seen     = CW'(c) + rot;
    assign rdata[c] = bank_q[seen];
  end
endmodule

// File: rtl/ring_regfile.sv
module ring_regfile
  import rrf_pkg::*;
#(
  parameter int NCL    = CLUSTERS,
  parameter int NPC    = PORTS_CL,
  parameter int DEPTH  = BANK_REGS,
  parameter int BUS_W  = WIDE_W,
  parameter int NAR_W  = SLIM_W,
  parameter logic [NCL-1:0] WIDE_MASK = WIDE_SET,
  localparam int NP    = NCL * NPC,
  localparam int CW    = $clog2(NCL),
  localparam int IW    = $clog2(DEPTH),
  localparam int AW    = IW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CW-1:0]               ring_rot,
  input  logic [NP-1:0][AW-1:0]       rd_addr,
  input  logic [NP-1:0]               rd_narrow,
  output logic [NP-1:0][BUS_W-1:0]    rd_data,
  input  logic [NP-1:0]               wr_en,
  input  logic [NP-1:0]               wr_narrow,
  input  logic [NP-1:0][AW-1:0]       wr_addr,
  input  logic [NP-1:0][BUS_W-1:0]    wr_data
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NCL-1:0][NPC-1:0]              ring_we;
  logic [NCL-1:0][NPC-1:0][IW-1:0]      ring_wa, ring_ra;
  logic [NCL-1:0][NPC-1:0][BUS_W-1:0]   wval;
  logic [NCL-1:0][NPC-1:0][NAR_W-1:0]   ring_q;
  logic [NCL-1:0][NPC-1:0][BUS_W-1:0]   priv_ext, ring_ext;

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    localparam int PW = WIDE_MASK[c] ? BUS_W : NAR_W;
    logic [NPC-1:0]           pv_we;
    logic [NPC-1:0][IW-1:0]   pv_wa, pv_ra;
    logic [NPC-1:0][PW-1:0]   pv_q;

    for (genvar k = 0; k < NPC; k++) begin : g_pt
      localparam int P = c * NPC + k;
      assign wval[c][k]    = wr_narrow[P]
                           ? {{(BUS_W-NAR_W){wr_data[P][NAR_W-1]}}, wr_data[P][NAR_W-1:0]}
                           : wr_data[P];
      assign pv_we[k]      = wr_en[P] & ~wr_addr[P][AW-1];
      assign ring_we[c][k] = wr_en[P] &  wr_addr[P][AW-1];
      assign pv_wa[k]      = wr_addr[P][IW-1:0];
      assign ring_wa[c][k] = wr_addr[P][IW-1:0];
      assign pv_ra[k]      = rd_addr[P][IW-1:0];
      assign ring_ra[c][k] = rd_addr[P][IW-1:0];
      assign ring_ext[c][k] = {{(BUS_W-NAR_W){ring_q[c][k][NAR_W-1]}}, ring_q[c][k]};

      if (PW < BUS_W) begin : g_ext
        assign priv_ext[c][k] = {{(BUS_W-PW){pv_q[k][PW-1]}}, pv_q[k]};
      end else begin : g_full
        assign priv_ext[c][k] = pv_q[k];
      end

      always_comb begin
        logic [BUS_W-1:0] pick;
        pick = rd_addr[P][AW-1] ? ring_ext[c][k] : priv_ext[c][k];
        rd_data[P] = rd_narrow[P] ? {{(BUS_W-NAR_W){1'b0}}, pick[NAR_W-1:0]} : pick;
      end
    end

    rrf_bank #(.W(PW), .DEPTH(DEPTH), .NW(NPC), .NR(NPC), .BUS_W(BUS_W)) u_priv (
      .clk  (clk),
      .rst_n(rst_int_n),
      .we   (pv_we),
      .waddr(pv_wa),
      .wdata(wval[c]),
      .raddr(pv_ra),
      .rdata(pv_q)
    );
  end

  rrf_ring #(.NCL(NCL), .NP(NPC), .DEPTH(DEPTH), .RING_W(NAR_W), .BUS_W(BUS_W)) u_ring (
    .clk  (clk),
    .rst_n(rst_int_n),
    .rot  (ring_rot),
    .we   (ring_we),
    .waddr(ring_wa),
    .wdata(wval),
    .raddr(ring_ra),
    .rdata(ring_q)
  );
endmodule

// File: rtl/rrf_chk.sv
module rrf_chk #(
  parameter int NP    = 8,
  parameter int AW    = 4,
  parameter int BUS_W = 40,
  parameter int NAR_W = 32,
  parameter int CW    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CW-1:0]            ring_rot,
  input logic [NP-1:0][AW-1:0]    rd_addr,
  input logic [NP-1:0]            rd_narrow,
  input logic [NP-1:0][BUS_W-1:0] rd_data,
  input logic [NP-1:0]            wr_en,
  input logic [NP-1:0]            wr_narrow,
  input logic [NP-1:0][AW-1:0]    wr_addr,
  input logic [NP-1:0][BUS_W-1:0] wr_data
);
  localparam int PA = NP - 2;
  localparam int PB = NP - 1;
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) ##1 ($stable(rd_addr) && $stable(rd_narrow) && $stable(ring_rot))
    |-> $stable(rd_data)); // R10

  AST_PORT1_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en[PA] && wr_en[PB] && !wr_addr[PB][AW-1] &&
                      wr_addr[PA] == wr_addr[PB] && !wr_narrow[PB]) &&
     rd_addr[PA] == $past(wr_addr[PB]) && !rd_narrow[PA])
    |-> rd_data[PA] == $past(wr_data[PB])); // R6

  AST_NEXT_CYCLE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en[PA] && !wr_en[PB] && !wr_addr[PA][AW-1] && !wr_narrow[PA]) &&
     rd_addr[PA] == $past(wr_addr[PA]) && !rd_narrow[PA])
    |-> rd_data[PA] == $past(wr_data[PA])); // R5

  for (genvar p = 0; p < NP; p++) begin : g_p
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_narrow[p] |-> rd_data[p][BUS_W-1:NAR_W] == '0); // R9
    if (p < 4) begin : g_slim
      AST_SLIM_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_narrow[p] |-> rd_data[p][BUS_W-1:NAR_W] == {(BUS_W-NAR_W){rd_data[p][NAR_W-1]}}); // R7
    end
  end
endmodule

bind ring_regfile rrf_chk #(.NP(NP), .AW(AW), .BUS_W(BUS_W), .NAR_W(NAR_W), .CW(CW)) u_rrf_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ring_rot (ring_rot),
  .rd_addr  (rd_addr),
  .rd_narrow(rd_narrow),
  .rd_data  (rd_data),
  .wr_en    (wr_en),
  .wr_narrow(wr_narrow),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/tb_ring_regfile.sv
module tb_ring_regfile;
  localparam int NP = 8;
  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           ring_rot;
  logic [NP-1:0][3:0]   rd_addr;
  logic [NP-1:0]        rd_narrow;
  logic [NP-1:0][39:0]  rd_data;
  logic [NP-1:0]        wr_en;
  logic [NP-1:0]        wr_narrow;
  logic [NP-1:0][3:0]   wr_addr;
  logic [NP-1:0][39:0]  wr_data;

  ring_regfile dut (
    .clk(clk), .rst_n(rst_n), .ring_rot(ring_rot),
    .rd_addr(rd_addr), .rd_narrow(rd_narrow), .rd_data(rd_data),
    .wr_en(wr_en), .wr_narrow(wr_narrow), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          port;
    logic [39:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic begin_cyc(input logic [1:0] rot);
    @(negedge clk);
    wr_en     = '0;
    wr_narrow = '0;
    rd_narrow = '0;
    ring_rot  = rot;
  endtask

  task automatic end_cyc();
    @(posedge clk);
  endtask

  task automatic wr(input int p, input logic [3:0] a, input logic [39:0] d, input bit nar);
    wr_en[p]     = 1'b1;
    wr_addr[p]   = a;
    wr_data[p]   = d;
    wr_narrow[p] = nar;
  endtask

  task automatic rd(input int p, input logic [3:0] a, input bit nar,
                    input logic [39:0] e, input string r);
    item_t it;
    rd_addr[p]   = a;
    rd_narrow[p] = nar;
    it.port = p; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (rd_data[it.port] !== it.exp) begin
          fails++;
          $display("FAIL %s port %0d: got %h expected %h", it.req, it.port,
                   rd_data[it.port], it.exp);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; ring_rot = '0; rd_addr = '0; rd_narrow = '0;
    wr_en = '0; wr_narrow = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    begin_cyc(2'd0);  // R1 reset state
    rd(0, 4'd0, 0, 40'h0, "R1"); rd(2, 4'd5, 0, 40'h0, "R1");
    rd(4, 4'd8, 0, 40'h0, "R1"); rd(6, 4'd15, 0, 40'h0, "R1");
    end_cyc();

    begin_cyc(2'd0);  // R5 old value in write cycle
    wr(6, 4'd2, 40'h12_3456_789A, 0);
    rd(6, 4'd2, 0, 40'h0, "R5");
    end_cyc();

    begin_cyc(2'd0);
    rd(6, 4'd2, 0, 40'h12_3456_789A, "R5");
    rd(4, 4'd2, 0, 40'h0, "R2");
    rd(0, 4'd2, 0, 40'h0, "R2");
    end_cyc();

    begin_cyc(2'd0);
    wr(0, 4'd1, 40'hAB_8000_0001, 0);
    wr(4, 4'd4, 40'h00_F000_0000, 1);
    end_cyc();

    begin_cyc(2'd0);
    rd(1, 4'd1, 0, 40'hFF_8000_0001, "R7");
    rd(4, 4'd4, 0, 40'hFF_F000_0000, "R8");
    rd(5, 4'd4, 1, 40'h00_F000_0000, "R9");
    end_cyc();

    begin_cyc(2'd0);  // R6 same-register double writes
    wr(6, 4'd5, 40'h11, 0); wr(7, 4'd5, 40'h22, 0);
    wr(2, 4'd6, 40'h33, 0); wr(3, 4'd6, 40'h44, 1);
    end_cyc();

    begin_cyc(2'd0);
    rd(7, 4'd5, 0, 40'h22, "R6");
    rd(2, 4'd6, 0, 40'h44, "R6");
    end_cyc();

    begin_cyc(2'd0);  // cluster 0 shared reg 3 -> bank 0
    wr(0, 4'd11, 40'h55, 0);
    end_cyc();

    begin_cyc(2'd3);  // R3 wrap: cluster1 sees bank 0, cluster0 bank 3
    rd(2, 4'd11, 0, 40'h55, "R3");
    rd(0, 4'd11, 0, 40'h0, "R3");
    wr(2, 4'd9, 40'h12_8000_0000, 0);  // R4: goes to bank 0 under rot 3
    end_cyc();

    begin_cyc(2'd2);
    rd(4, 4'd11, 0, 40'h55, "R3");
    rd(5, 4'd9, 0, 40'hFF_8000_0000, "R4");
    rd(2, 4'd9, 0, 40'h0, "R4");
    end_cyc();

    begin_cyc(2'd1);  // all clusters write shared reg 4 at rot 1
    for (int c = 0; c < 4; c++) wr(c*2, 4'd12, 40'(c+1), 0);
    end_cyc();

    begin_cyc(2'd0);
    rd(0, 4'd12, 0, 40'd4, "R3"); rd(2, 4'd12, 0, 40'd1, "R3");
    rd(4, 4'd12, 0, 40'd2, "R3"); rd(6, 4'd12, 0, 40'd3, "R3");
    end_cyc();

    begin_cyc(2'd0);  // R10 disabled port with live address/data
    wr(6, 4'd2, 40'hFF_FFFF_FFFF, 0);
    wr(7, 4'd5, 40'hFF_FFFF_FFFF, 0);
    wr_en = '0;
    end_cyc();

    begin_cyc(2'd0);
    rd(6, 4'd2, 0, 40'h12_3456_789A, "R10");
    rd(7, 4'd5, 0, 40'h22, "R10");
    end_cyc();

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule